// File: doc/BRIEF.md
# Reversible Multi-Function One-Bit ALU Cell

This block is a purely combinational four-wire reversible cell. Every function comes from cascading two copies of one three-wire primitive, the G gate. For wires (a, b, c) this primitive drives the following outputs, all from values taken before the gate:

- a becomes NOT a.
- b becomes a XOR b.
- c becomes c XOR (a AND b).

An opcode selects how the two auxiliary wires are preset. It also selects whether an inverter sits between and after the two gates. In this way one structure computes:

- full addition and full subtraction;
- AND, OR, NAND, NOR, XOR and XNOR;
- NOT of the first operand.

No output wire is garbage.

The four wires are numbered w1..w4 and carried as a vector with w1 in bit 0 and w4 in bit 3. The cell has two sources for the input vector:

- **Operand mode:** the vector is built from the operands X and Y, the carry or borrow input, and the opcode.
- **Raw mode:** the vector is supplied directly.

A direction input selects between two mappings:

- **Forward:** the cell evaluates the function.
- **Reverse:** the cell applies the exact inverse mapping. Feeding a forward result back in reverse mode recovers the original vector, which shows that no information is lost.

The cell has no clock and no handshake. Outputs depend only on the present inputs. The cell is a plain combinational stage, so it never exerts back-pressure. Any stream wrapper around it simply forwards its ready signal.

Top module: `rev_alu_cell`

## Requirements
- R1: In the forward direction, for every opcode from 0 to 5, output w1 (bit 0) equals NOT of input w1. In operand mode, input w1 is X.
- R2: With opcode 0 (add) in operand mode, the vector is loaded as w1=X, w2=0, w3=Y, w4=Cin. The forward outputs are:
  - {w2, w4} (bits 1 and 3) equal the two-bit value X+Y+Cin;
  - w3 (bit 2) equals XNOR(X,Y).
- R3: With opcode 1 (subtract) in operand mode, the vector is loaded as w1=X, w2=Y, w3=Y, w4=Bin. The forward outputs are:
  - w4 (bit 3) is the difference bit of X−Y−Bin;
  - w2 (bit 1) is 1 exactly when X−Y−Bin is negative;
  - w3 (bit 2) equals X XOR Y.
- R4: With opcode 2 (AND) in operand mode, the vector is loaded as w1=X, w2=0, w3=Y, w4=0. The forward outputs are:
  - w2 equals X AND Y;
  - w4 equals X XOR Y;
  - w3 equals XNOR(X,Y).
- R5: With opcode 3 (OR) in operand mode, the vector is loaded as w1=X, w2=0, w3=Y, w4=1. Forward w2 equals X OR Y.
- R6: With opcode 4 (NAND) in operand mode, the vector is loaded as w1=X, w2=1, w3=Y, w4=0. Forward w2 equals NOT(X AND Y).
- R7: With opcode 5 (NOR) in operand mode, the vector is loaded as w1=X, w2=1, w3=Y, w4=1. Forward w2 equals NOT(X OR Y).
- R8: Opcodes 6 and 7 pass the input vector to the output unchanged in both directions. In operand mode they load w1=X, w2=0, w3=Y, w4=Cin.
- R9: For every opcode and each of the 16 input vectors, the forward output fed back with reverse=1 returns the original vector.
- R10: For every opcode, the 16 forward outputs over all raw input vectors are pairwise distinct.
- R11: With sel_raw=1 the vector is raw_in and the operand inputs have no effect. In opcodes 2 to 5 the carry input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 3 | Function select: 0 add, 1 subtract, 2 AND, 3 OR, 4 NAND, 5 NOR, 6/7 pass |
| reverse | input | 1 | 0 evaluates forward, 1 applies the inverse mapping |
| sel_raw | input | 1 | 1 takes the wire vector from raw_in, 0 builds it from the operands |
| raw_in | input | 4 | Direct wire vector, w1 in bit 0 |
| opnd_x | input | 1 | Operand X |
| opnd_y | input | 1 | Operand Y |
| carry_in | input | 1 | Carry in for add, borrow in for subtract |
| wires_out | output | 4 | Resulting wire vector, w1 in bit 0 |

## Verification
The bound checker watches the forward arithmetic continuously:

- the inverted first wire;
- the add and subtract result bits;
- the logic result on w2 for each logic opcode;
- the identity of the pass codes.

Whatever inputs are applied, these must hold. Two properties span two separate evaluations of the cell and can only be shown by the bench's sweeps:

- that reverse mode undoes forward mode;
- that each opcode is a bijection over all 16 vectors.

Also shown only by the bench: outputs do not move when operands or the carry are toggled in a mode that ignores them.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int WIRES = 4;
  localparam int OPW   = 3;
  // wire positions inside the vector; the gate cascade depends on them
  localparam int W1 = 0;
  localparam int W2 = 1;
  localparam int W3 = 2;
  localparam int W4 = 3;
  localparam int LAST_ACTIVE = 5;

  typedef logic [WIRES-1:0] wvec_t;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_NAND = 3'd4,
    OP_NOR  = 3'd5,
    OP_PSA  = 3'd6,
    OP_PSB  = 3'd7
  } op_e;
endpackage

// File: rtl/rvc_gate.sv
module rvc_gate #(
  parameter bit INVERSE = 1'b0
) (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic a_o,
  output logic b_o,
  output logic c_o
);
  generate
    if (INVERSE) begin : g_inv
      logic a_rec;
      logic b_rec;
      assign a_rec = ~a_i;
      assign b_rec = b_i ^ a_rec;
      assign a_o   = a_rec;
      assign b_o   = b_rec;
      assign c_o   = c_i ^ (a_rec & b_rec);
    end else begin : g_fwd
      assign a_o = ~a_i;
      assign b_o = a_i ^ b_i;
      assign c_o = c_i ^ (a_i & b_i);
    end
  endgenerate
endmodule

// File: rtl/rvc_loader.sv
module rvc_loader
  import rvc_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic           sel_raw,
  input  wvec_t          raw_in,
  input  logic           opnd_x,
  input  logic           opnd_y,
  input  logic           carry_in,
  output wvec_t          vec_o
);
  always_comb begin
    vec_o     = '0;
    vec_o[W1] = opnd_x;
    vec_o[W3] = opnd_y;
    if (sel_raw) begin
      vec_o = raw_in;
    end else begin
      unique case (op_e'(op_code))
        OP_SUB: begin
          vec_o[W2] = opnd_y;
          vec_o[W4] = carry_in;
        end
        OP_AND:  begin vec_o[W2] = 1'b0; vec_o[W4] = 1'b0; end
        OP_OR:   begin vec_o[W2] = 1'b0; vec_o[W4] = 1'b1; end
        OP_NAND: begin vec_o[W2] = 1'b1; vec_o[W4] = 1'b0; end
        OP_NOR:  begin vec_o[W2] = 1'b1; vec_o[W4] = 1'b1; end
        default: begin vec_o[W2] = 1'b0; vec_o[W4] = carry_in; end
      endcase
    end
  end
endmodule

// File: rtl/rvc_cascade.sv
module rvc_cascade
  import rvc_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic           reverse,
  input  wvec_t          vec_i,
  output wvec_t          vec_o
);
  logic is_sub;
  logic active;
  assign is_sub = (op_e'(op_code) == OP_SUB);
  assign active = (int'(op_code) <= LAST_ACTIVE);

  // forward: stage A (a=w1,b=w3,c=w2), optional NOT w3, stage B (a=w3,b=w4,c=w2), optional NOT w4
  wvec_t fa, fm, fb, fwd;
  assign fa[W4] = vec_i[W4];

  rvc_gate #(.INVERSE(1'b0)) u_fwd_a (
    .a_i(vec_i[W1]), .b_i(vec_i[W3]), .c_i(vec_i[W2]),
    .a_o(fa[W1]),    .b_o(fa[W3]),    .c_o(fa[W2])
  );

  always_comb begin
    fm     = fa;
    fm[W3] = fa[W3] ^ is_sub;
  end

  assign fb[W1] = fm[W1];

  rvc_gate #(.INVERSE(1'b0)) u_fwd_b (
    .a_i(fm[W3]), .b_i(fm[W4]), .c_i(fm[W2]),
    .a_o(fb[W3]), .b_o(fb[W4]), .c_o(fb[W2])
  );

  always_comb begin
    fwd     = fb;
    fwd[W4] = fb[W4] ^ is_sub;
  end

  // inverse: undo the steps above in reverse order
  wvec_t ip, iq, im, inv;
  always_comb begin
    ip     = vec_i;
    ip[W4] = vec_i[W4] ^ is_sub;
  end

  assign iq[W1] = ip[W1];

  rvc_gate #(.INVERSE(1'b1)) u_inv_b (
    .a_i(ip[W3]), .b_i(ip[W4]), .c_i(ip[W2]),
    .a_o(iq[W3]), .b_o(iq[W4]), .c_o(iq[W2])
  );

  always_comb begin
    im     = iq;
    im[W3] = iq[W3] ^ is_sub;
  end

  assign inv[W4] = im[W4];

  rvc_gate #(.INVERSE(1'b1)) u_inv_a (
    .a_i(im[W1]),  .b_i(im[W3]),  .c_i(im[W2]),
    .a_o(inv[W1]), .b_o(inv[W3]), .c_o(inv[W2])
  );

  always_comb begin
    if (!active)      vec_o = vec_i;
    else if (reverse) vec_o = inv;
    else              vec_o = fwd;
  end
endmodule

// File: rtl/rev_alu_cell.sv
module rev_alu_cell
  import rvc_pkg::*;
(
  input  logic [2:0] op_code,
  input  logic       reverse,
  input  logic       sel_raw,
  input  logic [3:0] raw_in,
  input  logic       opnd_x,
  input  logic       opnd_y,
  input  logic       carry_in,
  output logic [3:0] wires_out
);
  wvec_t loaded;

  rvc_loader u_loader (
    .op_code (op_code),
    .sel_raw (sel_raw),
    .raw_in  (raw_in),
    .opnd_x  (opnd_x),
    .opnd_y  (opnd_y),
    .carry_in(carry_in),
    .vec_o   (loaded)
  );

  rvc_cascade u_cascade (
    .op_code(op_code),
    .reverse(reverse),
    .vec_i  (loaded),
    .vec_o  (wires_out)
  );
endmodule

// File: rtl/rev_alu_cell_chk.sv
module rev_alu_cell_chk (
  input logic [2:0] op_code,
  input logic       reverse,
  input logic       sel_raw,
  input logic [3:0] raw_in,
  input logic       opnd_x,
  input logic       opnd_y,
  input logic       carry_in,
  input logic [3:0] wires_out
);
  logic [1:0] add_val;
  logic       brw;
  logic       ctl_in;
  assign add_val = {1'b0, opnd_x} + {1'b0, opnd_y} + {1'b0, carry_in};
  assign brw     = (~opnd_x & opnd_y) | (~(opnd_x ^ opnd_y) & carry_in);
  assign ctl_in  = sel_raw ? raw_in[0] : opnd_x;

  always_comb begin
    if (!reverse && op_code <= 3'd5) begin
      p_not_ctl_r1: assert (wires_out[0] == ~ctl_in)
        else $error("R1 w1 not inverted");
    end
    if (!reverse && !sel_raw && op_code == 3'd0) begin
      p_add_r2: assert ({wires_out[1], wires_out[3]} == add_val)
        else $error("R2 add mismatch");
    end
    if (!reverse && !sel_raw && op_code == 3'd1) begin
      p_sub_r3: assert (wires_out[3] == (opnd_x ^ opnd_y ^ carry_in) && wires_out[1] == brw)
        else $error("R3 subtract mismatch");
    end
    if (!reverse && !sel_raw && op_code == 3'd2) begin
      p_and_r4: assert (wires_out[1] == (opnd_x & opnd_y)) else $error("R4 and");
    end
    if (!reverse && !sel_raw && op_code == 3'd3) begin
      p_or_r5: assert (wires_out[1] == (opnd_x | opnd_y)) else $error("R5 or");
    end
    if (!reverse && !sel_raw && op_code == 3'd4) begin
      p_nand_r6: assert (wires_out[1] == ~(opnd_x & opnd_y)) else $error("R6 nand");
    end
    if (!reverse && !sel_raw && op_code == 3'd5) begin
      p_nor_r7: assert (wires_out[1] == ~(opnd_x | opnd_y)) else $error("R7 nor");
    end
    if (sel_raw && op_code >= 3'd6) begin
      p_pass_r8: assert (wires_out == raw_in) else $error("R8 pass");
    end
  end
endmodule

bind rev_alu_cell rev_alu_cell_chk u_chk (
  .op_code  (op_code),
  .reverse  (reverse),
  .sel_raw  (sel_raw),
  .raw_in   (raw_in),
  .opnd_x   (opnd_x),
  .opnd_y   (opnd_y),
  .carry_in (carry_in),
  .wires_out(wires_out)
);

// File: tb/rev_alu_cell_bench.sv
`timescale 1ns/1ps
module rev_alu_cell_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_code = '0;
  logic       reverse = 1'b0;
  logic       sel_raw = 1'b0;
  logic [3:0] raw_in = '0;
  logic       opnd_x = 1'b0;
  logic       opnd_y = 1'b0;
  logic       carry_in = 1'b0;
  logic [3:0] wires_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rev_alu_cell u_rev_alu_cell (
    .op_code(op_code), .reverse(reverse), .sel_raw(sel_raw), .raw_in(raw_in),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .carry_in(carry_in), .wires_out(wires_out)
  );

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s op=%0d actual=%b expected=%b", req, op_code, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] fwd_tab [16];
    logic [3:0] exp_v;
    logic [3:0] keep;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // R2: idle state after reset, add of zeros -> w1=1,w2=0,w3=1,w4=0
    chk(wires_out == 4'b0101, "R2 reset state", wires_out, 4'b0101);

    // operand sweeps, expected values arithmetic
    for (int op = 0; op < 6; op++) begin
      for (int k = 0; k < 8; k++) begin
        int xi, yi, ci, s;
        xi = (k >> 2) & 1; yi = (k >> 1) & 1; ci = k & 1;
        op_code = 3'(op); sel_raw = 1'b0; reverse = 1'b0;
        opnd_x = xi[0]; opnd_y = yi[0]; carry_in = ci[0];
        settle();
        chk(wires_out[0] == ~opnd_x, "R1", wires_out, {wires_out[3:1], ~opnd_x});
        case (op)
          0: begin
            s = xi + yi + ci;
            exp_v = {s[0], ~(xi[0] ^ yi[0]), s[1], ~xi[0]};
            chk(wires_out == exp_v, "R2 add", wires_out, exp_v);
          end
          1: begin
            s = xi - yi - ci;
            exp_v = {s[0], xi[0] ^ yi[0], (s < 0) ? 1'b1 : 1'b0, ~xi[0]};
            chk(wires_out == exp_v, "R3 sub", wires_out, exp_v);
          end
          2: begin
            exp_v = {xi[0] ^ yi[0], ~(xi[0] ^ yi[0]), xi[0] & yi[0], ~xi[0]};
            chk(wires_out == exp_v, "R4 and", wires_out, exp_v);
          end
          3: chk(wires_out[1] == (xi[0] | yi[0]), "R5 or", wires_out, {2'b0, xi[0] | yi[0], 1'b0});
          4: chk(wires_out[1] == ~(xi[0] & yi[0]), "R6 nand", wires_out, {2'b0, ~(xi[0] & yi[0]), 1'b0});
          default: chk(wires_out[1] == ~(xi[0] | yi[0]), "R7 nor", wires_out, {2'b0, ~(xi[0] | yi[0]), 1'b0});
        endcase
        if (op >= 2) begin
          // R11: carry ignored in logic modes
          keep = wires_out;
          carry_in = ~carry_in;
          settle();
          chk(wires_out == keep, "R11 carry ignored", wires_out, keep);
        end
      end
    end

    // R8: pass codes in operand mode
    for (int op = 6; op < 8; op++) begin
      op_code = 3'(op); sel_raw = 1'b0; reverse = 1'b0;
      opnd_x = 1'b1; opnd_y = 1'b0; carry_in = 1'b1;
      settle();
      chk(wires_out == 4'b1001, "R8 pass operand", wires_out, 4'b1001);
    end

    // raw sweeps: bijection, round trip, pass codes
    for (int op = 0; op < 8; op++) begin
      logic [15:0] seen;
      seen = '0;
      op_code = 3'(op); sel_raw = 1'b1;
      for (int v = 0; v < 16; v++) begin
        reverse = 1'b0; raw_in = 4'(v);
        settle();
        fwd_tab[v] = wires_out;
        seen[wires_out] = 1'b1;
        if (op >= 6) chk(wires_out == 4'(v), "R8 pass fwd", wires_out, 4'(v));
        else chk(wires_out[0] == ~raw_in[0], "R1 raw", wires_out, {wires_out[3:1], ~raw_in[0]});
        reverse = 1'b1; raw_in = fwd_tab[v];
        settle();
        chk(wires_out == 4'(v), "R9 round trip", wires_out, 4'(v));
      end
      chk(seen == 16'hFFFF, "R10 distinct", 4'($countones(seen) & 15), 4'd0);
      // R11: operands ignored in raw mode
      reverse = 1'b0; raw_in = 4'b0110; opnd_x = 1'b0; opnd_y = 1'b0; carry_in = 1'b0;
      settle();
      keep = wires_out;
      opnd_x = 1'b1; opnd_y = 1'b1; carry_in = 1'b1;
      settle();
      chk(wires_out == keep && keep == fwd_tab[6], "R11 operands ignored", wires_out, fwd_tab[6]);
    end

    finish_run();
  end
endmodule